// File: doc/BRIEF.md
# BCD Countdown Watchdog

This block is a watchdog timer that counts down a timeout written as binary-coded decimal. The timeout has four digits: two digits of seconds and two digits of hundredths, so the longest timeout is 99.99 s. The block shares a byte-wide register bus with its neighbours and needs an external strobe, `tick_i`, that pulses once every 10 ms. Software arms the watchdog by writing the two timeout bytes and setting the enable bit. It keeps the watchdog from expiring by rewriting either timeout byte, which reloads the running count.

When the count runs out, the block sets a sticky flag. A steering bit decides what happens next. With steering set, the block drives an active-low reset pulse of fixed length. With steering clear, it raises an interrupt that stays high until software reads the status register.

A timeout of zero never expires. Clearing the enable bit freezes the count where it is.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset, `wdog_rst_no` is 1, `irq_o` is 0, and all four registers read 0x00.
- R2: The registers sit at fixed offsets and return their stored value on `rdata_o` in the cycle after `rd_en_i`:
  - 0x0C holds the hundredths byte.
  - 0x0D holds the seconds byte.
  - 0x0E is status, with the flag in bit 1.
  - 0x0F is control, with enable in bit 1 and steering in bit 0.
  - Unused bits read 0.
- R3: A write to 0x0C or 0x0D reloads the running count from the updated pair of timeout bytes. This restarts the full timeout.
- R4: While enabled, each tick lowers the count by one hundredth in BCD, borrowing across digits. A load of 01.00 therefore expires on exactly the 100th tick.
- R5: The tick that takes the count from 00.01 to 00.00 sets the flag. The count then stays at zero, and no further expiry happens until the next reload.
- R6: When steering is 1 at expiry, `wdog_rst_no` goes low on the expiry edge and stays low for exactly PULSE_CYC cycles. `irq_o` stays low.
- R7: When steering is 0 at expiry, `irq_o` goes high on the expiry edge and stays high while the flag is set. No reset pulse is driven.
- R8: A read of the status register returns the flag and clears it. Writes to the status register are ignored.
- R9: With a zero count, ticks cause no expiry, no flag, no interrupt and no reset pulse.
- R10: With enable at 0, ticks do not change the count. Setting enable again resumes the countdown from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz count strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (5) | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_en_i` |
| wdog_rst_no | output | 1 | Reset pulse on expiry, active low |
| irq_o | output | 1 | Interrupt on expiry, active high |

## Verification
The bench builds the block with its default parameters: two timeout bytes (four BCD digits), a 16-cycle reset pulse and a 5-bit address. The bench drives `tick_i` on every clock, which speeds the count up enough to reach several cases:

- the full 99.99 s timeout, about ten thousand ticks;
- the borrow from 01.00 down to 00.99;
- a kick in the middle of a countdown;
- a pause and resume through the enable bit;
- the exact length of the reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [4:0] ADDR_CNT_BASE = 5'h0C;
  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_STEER_BIT = 0;
  localparam int STAT_FLAG_BIT  = 1;

  function automatic logic [3:0] bcd_dec(input logic [3:0] d);
    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CNT_BYTES = 2,
  localparam int CW       = 8 * CNT_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              fire_i,
  output logic              load_o,
  output logic [CW-1:0]     load_val_o,
  output logic              en_o,
  output logic              steer_o,
  output logic              flag_o,
  output logic              src_rst_o,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(ADDR_CNT_BASE);
  localparam logic [ADDR_W-1:0] A_STAT = A_BASE + ADDR_W'(CNT_BYTES);
  localparam logic [ADDR_W-1:0] A_CTRL = A_STAT + ADDR_W'(1);

  logic [7:0]           cnt_byte_q [CNT_BYTES];
  logic [CNT_BYTES-1:0] hit;
  logic                 flag_q, src_rst_q, en_q, steer_q;
  logic                 stat_rd;

  for (genvar i = 0; i < CNT_BYTES; i++) begin : g_byte
    assign hit[i] = wr_en_i && (addr_i == A_BASE + ADDR_W'(i));
    assign load_val_o[8*i +: 8] = hit[i] ? wdata_i : cnt_byte_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_byte_q[i] <= '0;
      else if (hit[i]) cnt_byte_q[i] <= wdata_i;
    end
  end

  assign load_o  = |hit;
  assign stat_rd = rd_en_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      steer_q <= 1'b0;
    end else if (wr_en_i && addr_i == A_CTRL) begin
      en_q    <= wdata_i[CTRL_EN_BIT];
      steer_q <= wdata_i[CTRL_STEER_BIT];
    end
  end

  // set has priority over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= 1'b0;
      src_rst_q <= 1'b0;
    end else if (fire_i) begin
      flag_q    <= 1'b1;
      src_rst_q <= steer_q;
    end else if (stat_rd) begin
      flag_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      rdata_o <= '0;
      for (int i = 0; i < CNT_BYTES; i++)
        if (addr_i == A_BASE + ADDR_W'(i)) rdata_o <= cnt_byte_q[i];
      if (addr_i == A_STAT) rdata_o[STAT_FLAG_BIT] <= flag_q;
      if (addr_i == A_CTRL) begin
        rdata_o[CTRL_EN_BIT]    <= en_q;
        rdata_o[CTRL_STEER_BIT] <= steer_q;
      end
    end
  end

  assign en_o      = en_q;
  assign steer_o   = steer_q;
  assign flag_o    = flag_q;
  assign src_rst_o = src_rst_q;

  assert_flag_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> flag_q);
  assert_rd_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !fire_i) |=> !flag_q);
endmodule

// File: rtl/wdt_bcd_cnt.sv
module wdt_bcd_cnt
  import wdt_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int CW    = 4 * DIGITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  input  logic          en_i,
  output logic          fire_o
);
  logic [CW-1:0]   cnt_q, cnt_dec;
  logic [DIGITS:0] borrow;
  logic            active;

  assign borrow[0] = 1'b1;
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign borrow[i+1]      = borrow[i] && (cnt_q[4*i +: 4] == 4'd0);
    assign cnt_dec[4*i +: 4] = borrow[i] ? bcd_dec(cnt_q[4*i +: 4]) : cnt_q[4*i +: 4];
  end

  assign active = tick_i && en_i && (cnt_q != '0) && !load_i;
  assign fire_o = active && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (active) cnt_q <= cnt_dec;
  end

  assert_zero_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  assert_hold_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
  assert_tick_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && !load_i && cnt_q != '0) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_CYC = 16,
  localparam int PW       = $clog2(PULSE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rst_no
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (start_i)        left_q <= PW'(PULSE_CYC);
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign rst_no = (left_q == '0);

  assert_pulse_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !rst_no);
  assert_no_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> $past(start_i));
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog #(
  parameter int ADDR_W    = 5,
  parameter int CNT_BYTES = 2,
  parameter int PULSE_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              wdog_rst_no,
  output logic              irq_o
);
  localparam int DIGITS = 2 * CNT_BYTES;
  localparam int CW     = 4 * DIGITS;

  logic          load, en, steer, flag, src_rst, fire;
  logic [CW-1:0] load_val;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_BYTES(CNT_BYTES)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .fire_i(fire), .load_o(load), .load_val_o(load_val), .en_o(en),
    .steer_o(steer), .flag_o(flag), .src_rst_o(src_rst), .rdata_o
  );

  wdt_bcd_cnt #(.DIGITS(DIGITS)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .tick_i, .en_i(en), .fire_o(fire)
  );

  wdt_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i, .rst_ni, .start_i(fire && steer), .rst_no(wdog_rst_no)
  );

  assign irq_o = flag && !src_rst;

  assert_steer_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && steer) |=> (!wdog_rst_no && !irq_o));
  assert_steer_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !steer) |=> irq_o);
endmodule

// File: tb/sim_bcd_watchdog.sv
module sim_bcd_watchdog;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       wdog_rst_no, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  localparam logic [4:0] A_HUND = 5'h0C, A_SEC = 5'h0D, A_STAT = 5'h0E, A_CTRL = 5'h0F;

  always #2 clk_i = ~clk_i;

  bcd_watchdog u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: result appears the cycle after rd_en
  always @(posedge clk_i) rd_seen <= rd_en_i;
  always @(negedge clk_i) if (rd_seen) begin
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R2 actual=%0h expected=none", rdata_o);
    end else begin
      chk(tag_q.pop_front(), int'(rdata_o), exp_q.pop_front());
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input int exp, input string tag);
    rd_en_i = 1'b1; addr_i = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int low;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 rst_no", wdog_rst_no, 1);
    chk("R1 irq", irq_o, 0);
    rd(A_HUND, 8'h00, "R1 hund"); rd(A_SEC, 8'h00, "R1 sec");
    rd(A_STAT, 8'h00, "R1 stat"); rd(A_CTRL, 8'h00, "R1 ctrl");
    // R2 map and unused bits
    wr(A_HUND, 8'h25); wr(A_SEC, 8'h37); wr(A_CTRL, 8'hFE);
    rd(A_HUND, 8'h25, "R2 hund"); rd(A_SEC, 8'h37, "R2 sec");
    rd(A_CTRL, 8'h02, "R2 ctrl");
    // R8 write to status ignored
    wr(A_STAT, 8'hFF);
    rd(A_STAT, 8'h00, "R8 stat write ignored");
    chk("R8 irq after stat write", irq_o, 0);
    // R5/R7 interrupt path, 00.05
    wr(A_SEC, 8'h00); wr(A_HUND, 8'h05);
    ticks(4); chk("R5 before expiry", irq_o, 0);
    ticks(1); chk("R7 irq on expiry", irq_o, 1);
    chk("R7 no reset pulse", wdog_rst_no, 1);
    rd(A_STAT, 8'h02, "R8 flag read");
    chk("R8 irq cleared", irq_o, 0);
    rd(A_STAT, 8'h00, "R8 flag cleared");
    ticks(20); chk("R5 no refire", irq_o, 0);
    // R4 borrow 01.00
    wr(A_HUND, 8'h00); wr(A_SEC, 8'h01);
    ticks(99); chk("R4 tick 99", irq_o, 0);
    ticks(1); chk("R4 tick 100", irq_o, 1);
    rd(A_STAT, 8'h02, "R4 flag");
    // R3 kick
    wr(A_SEC, 8'h00); wr(A_HUND, 8'h10);
    ticks(5); wr(A_HUND, 8'h10);
    ticks(9); chk("R3 no fire after kick", irq_o, 0);
    ticks(1); chk("R3 fire after full reload", irq_o, 1);
    rd(A_STAT, 8'h02, "R3 flag");
    // R10 pause
    wr(A_HUND, 8'h03); wr(A_CTRL, 8'h00);
    ticks(10); chk("R10 held while disabled", irq_o, 0);
    wr(A_CTRL, 8'h02);
    ticks(2); chk("R10 resumed tick 2", irq_o, 0);
    ticks(1); chk("R10 resumed tick 3", irq_o, 1);
    rd(A_STAT, 8'h02, "R10 flag");
    // R9 zero timeout
    wr(A_HUND, 8'h00); wr(A_SEC, 8'h00);
    ticks(50);
    chk("R9 irq", irq_o, 0); chk("R9 rst", wdog_rst_no, 1);
    rd(A_STAT, 8'h00, "R9 flag");
    // R6 reset path
    wr(A_CTRL, 8'h03); wr(A_HUND, 8'h02);
    ticks(1); chk("R6 before expiry", wdog_rst_no, 1);
    ticks(1);
    chk("R6 irq low", irq_o, 0);
    low = 0;
    while (!wdog_rst_no && low < 100) begin low++; @(negedge clk_i); end
    chk("R6 pulse length", low, 16);
    rd(A_STAT, 8'h02, "R6 flag");
    // R4 full scale 99.99
    wr(A_CTRL, 8'h02); wr(A_HUND, 8'h99); wr(A_SEC, 8'h99);
    ticks(9998); chk("R4 tick 9998", irq_o, 0);
    ticks(1); chk("R4 tick 9999", irq_o, 1);
    chk("R7 no pulse", wdog_rst_no, 1);
    repeat (3) @(negedge clk_i);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule